// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address engine of one DMA channel. Software programs a rectangular region as a start word address, a line length, a line count and a line-to-line stride, all counted in 4-byte words. Writing the start address launches the walk. The engine then issues one word address per accepted request on a valid/ready memory-side interface. Within a line the address steps by one. Each new line begins one stride after the start of the previous line, so a stride larger than the line length skips a gap between lines.

The address output always shows the live word address. Software can read it at any time and work out how many bytes are still outstanding. When the last word of the last line is accepted, the engine pulses a completion strobe for one cycle and goes idle. It then holds the address one past the final word. A stop input abandons a running walk at once, with no completion strobe.

Top module: `dma2d_agen`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `req_valid` and `done` are 0 and `req_addr` is 0.
- R2: A write with `cfg_sel` = 0 (start address, taken from `cfg_wdata[AW-1:0]` as a word address) while idle and with a nonzero line length sets `busy` from the next cycle, and `req_addr` then equals the written value.
- R3: While a line is running, each accepted request (`req_valid` and `req_ready` both high) advances `req_addr` by one word. With `req_ready` low, the address holds.
- R4: The first word of every line after the first is at the previous line's first word plus the stride (`cfg_sel` = 3), modulo 2^AW.
- R5: A walk issues exactly (lines − 1 register + 1) × line length requests. The line length is set with `cfg_sel` = 1 and the lines-minus-one count with `cfg_sel` = 2.
- R6: In the cycle after the last request is accepted, `done` is high for exactly one cycle and `busy` is low. `req_addr` then holds the last issued address plus one until the next start.
- R7: With `stop` high while busy, `req_valid` is low in that cycle and the engine is idle in the next one. `done` stays low and `req_addr` keeps its value.
- R8: A start write while the line length register is 0 is ignored: `busy` and `req_valid` stay low.
- R9: Configuration writes of any select while `busy` is high are ignored. They change neither the running walk nor the values used by the next walk.
- R10: The control word (`cfg_sel` = 4) bit 5 drives `req_dir` (1 = memory to device, 0 = device to memory). Bit 4 drives `req_burst` (1 = 4-word bursts, 0 = single words). Both stay steady for a whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 start, 1 line length, 2 lines minus one, 3 stride, 4 control |
| cfg_wdata | input | 32 | Configuration write data |
| stop | input | 1 | Abort the running walk |
| req_ready | input | 1 | Memory side accepts the current request |
| req_valid | output | 1 | A word request is presented |
| req_addr | output | AW | Current word address, also the readback value |
| req_dir | output | 1 | Transfer direction from control bit 5 |
| req_burst | output | 1 | Burst mode from control bit 4 |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with AW = 16 and LW = 8. This puts the top of the address space a few words from ordinary start values, so a walk can be placed to cross the 2^16 boundary. It also lets stride, length and line count cover zero, one, overlap and gap cases with short runs. The narrow counters also let walks with throttled `req_ready` finish quickly. This exposes whether the address holds exactly while requests wait.

// File: rtl/dma2d_pkg.sv
// Shared definitions for the two-dimensional address generator.
// Assumes a 3-bit register select and a control word whose bits 4 and 5
// carry burst mode and direction.
package dma2d_pkg;

    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_XLEN   = 3'd1,
        SEL_YLEN   = 3'd2,
        SEL_STRIDE = 3'd3,
        SEL_CTRL   = 3'd4
    } cfg_sel_e;

    localparam int CTRL_BURST_BIT = 4;
    localparam int CTRL_DIR_BIT   = 5;

    typedef struct packed {
        logic dir;
        logic burst;
    } ctrl_t;

endpackage

// File: rtl/dma2d_cfg.sv
// Configuration registers for one channel. Holds line length, line count,
// stride and control, and turns a start-address write into a launch pulse.
// Assumes DW >= AW and DW >= LW. Every write is dropped while busy is high,
// and a start is dropped while the line length is zero.
module dma2d_cfg
    import dma2d_pkg::*;
#(
    parameter int AW = 30,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic          go,
    output logic [AW-1:0] start_addr,
    output logic [LW-1:0] xlen,
    output logic [LW-1:0] ylen,
    output logic [LW-1:0] stride,
    output ctrl_t         ctrl
);

    logic wr_ok;

    // Writes are accepted only between walks.
    assign wr_ok = wr && !busy;

    // Launch on a start write, provided a line length is present.
    always_comb begin
        go         = wr_ok && (sel == SEL_START) && (xlen != '0);
        start_addr = wdata[AW-1:0];
    end

    // Parameter registers, loaded by select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlen   <= '0;
            ylen   <= '0;
            stride <= '0;
            ctrl   <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_XLEN:   xlen   <= wdata[LW-1:0];
                SEL_YLEN:   ylen   <= wdata[LW-1:0];
                SEL_STRIDE: stride <= wdata[LW-1:0];
                SEL_CTRL: begin
                    ctrl.dir   <= wdata[CTRL_DIR_BIT];
                    ctrl.burst <= wdata[CTRL_BURST_BIT];
                end
                default: ;
            endcase
        end
    end

    // R9: the parameter registers do not move during a walk.
    a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(xlen) && $stable(ylen) && $stable(stride)));

endmodule

// File: rtl/dma2d_walk.sv
// Address walker. Steps through the words of a line, jumps by the stride
// at each line end, and pulses done after the last word of the last line.
// Assumes the parameters stay steady while busy. Addresses wrap modulo 2^AW.
module dma2d_walk #(
    parameter int AW = 30,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] xlen,
    input  logic [LW-1:0] ylen,
    input  logic [LW-1:0] stride,
    input  logic          stop,
    input  logic          ready,
    output logic          valid,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] addr
);

    localparam logic [LW-1:0] ONE_L = LW'(1);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    logic [AW-1:0] line_base;
    logic [AW-1:0] next_base;
    logic [LW-1:0] xcnt;
    logic [LW-1:0] ycnt;
    logic          accept;
    logic          line_end;
    logic          last_line;

    // Request and step decisions for the current cycle.
    always_comb begin
        valid     = busy && !stop;
        accept    = valid && ready;
        line_end  = (xcnt + ONE_L) == xlen;
        last_line = ycnt == ylen;
        next_base = line_base + AW'(stride);
    end

    // Walk state: counters, line base, live address and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            addr      <= '0;
            line_base <= '0;
            xcnt      <= '0;
            ycnt      <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy      <= 1'b1;
                addr      <= start_addr;
                line_base <= start_addr;
                xcnt      <= '0;
                ycnt      <= '0;
            end else if (busy && stop) begin
                busy <= 1'b0;
            end else if (accept) begin
                if (!line_end) begin
                    xcnt <= xcnt + ONE_L;
                    addr <= addr + ONE_A;
                end else if (!last_line) begin
                    xcnt      <= '0;
                    ycnt      <= ycnt + ONE_L;
                    line_base <= next_base;
                    addr      <= next_base;
                end else begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    addr <= addr + ONE_A;
                end
            end
        end
    end

    // R3: inside a line an accepted word moves the address by one.
    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !line_end) |=> (addr == $past(addr) + ONE_A));

    // R3: a waiting request keeps its address.
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> $stable(addr));

    // R2: a launch presents the written start address.
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && addr == $past(start_addr)));

    // R6: the completion strobe lasts one cycle and finds the engine idle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R7: stop ends the walk without completion.
    a_r7_stop_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop && !go) |=> (!busy && !done && $stable(addr)));

endmodule

// File: rtl/dma2d_agen.sv
// Top of the two-dimensional DMA address generator: configuration
// registers feeding the walker. Assumes 4-byte words throughout. The
// address output doubles as the software readback of the live position.
module dma2d_agen
    import dma2d_pkg::*;
#(
    parameter int AW = 30,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          stop,
    input  logic          req_ready,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_dir,
    output logic          req_burst,
    output logic          busy,
    output logic          done
);

    localparam int DW = 32;

    logic          go;
    logic [AW-1:0] start_addr;
    logic [LW-1:0] xlen;
    logic [LW-1:0] ylen;
    logic [LW-1:0] stride;
    ctrl_t         ctrl;

    dma2d_cfg #(.AW(AW), .LW(LW), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .busy       (busy),
        .go         (go),
        .start_addr (start_addr),
        .xlen       (xlen),
        .ylen       (ylen),
        .stride     (stride),
        .ctrl       (ctrl)
    );

    dma2d_walk #(.AW(AW), .LW(LW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .start_addr (start_addr),
        .xlen       (xlen),
        .ylen       (ylen),
        .stride     (stride),
        .stop       (stop),
        .ready      (req_ready),
        .valid      (req_valid),
        .busy       (busy),
        .done       (done),
        .addr       (req_addr)
    );

    // Direction and burst qualifiers follow the control register.
    always_comb begin
        req_dir   = ctrl.dir;
        req_burst = ctrl.burst;
    end

    // R8: a start with no line length leaves the engine idle.
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_START && !busy && xlen == '0) |=> !busy);

    // R10: direction and burst stay put for a whole walk.
    a_r10_ctrl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(req_dir) && $stable(req_burst)));

endmodule

// File: tb/dma2d_agen_bench.sv
module dma2d_agen_bench;

    localparam int AW = 16;
    localparam int LW = 8;
    localparam int MASK = (1 << AW) - 1;

    typedef struct packed {
        logic [15:0] start;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [7:0]  stride;
        logic        dir;
        logic        burst;
        logic        slow;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 8'd4, 8'd2, 8'd4, 1'b0, 1'b0, 1'b0},  // contiguous lines
        '{16'h0200, 8'd3, 8'd3, 8'd8, 1'b1, 1'b0, 1'b1},  // gap between lines
        '{16'h1000, 8'd1, 8'd0, 8'd1, 1'b0, 1'b1, 1'b0},  // single word
        '{16'hFFFC, 8'd5, 8'd1, 8'd6, 1'b1, 1'b1, 1'b1},  // wraps past 2^16
        '{16'h0300, 8'd8, 8'd2, 8'd2, 1'b0, 1'b1, 1'b0},  // overlapping lines
        '{16'h0040, 8'd2, 8'd4, 8'd0, 1'b1, 1'b0, 1'b1}   // zero stride repeats
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          stop = 1'b0;
    logic          req_ready = 1'b0;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_dir;
    logic          req_burst;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma2d_agen #(.AW(AW), .LW(LW)) u_dma2d_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .stop      (stop),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_dir   (req_dir),
        .req_burst (req_burst),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic int exp_addr(input vec_t v, input int k);
        return (int'(v.start) + (k / int'(v.x)) * int'(v.stride) + (k % int'(v.x))) & MASK;
    endfunction

    // Programs one vector, runs it to completion and checks every request.
    task automatic run_vec(input vec_t v);
        int total, k, cyc, last;
        bit seen;
        total = int'(v.x) * (int'(v.y) + 1);
        wr(3'd1, 32'(v.x));
        wr(3'd2, 32'(v.y));
        wr(3'd3, 32'(v.stride));
        wr(3'd4, {26'b0, v.dir, v.burst, 4'b0});
        wr(3'd0, 32'(v.start));
        chk(busy && req_addr == v.start, "R2", int'(req_addr), int'(v.start));
        k = 0; cyc = 0; seen = 1'b0; last = 0;
        while (!seen && cyc < 4000) begin
            req_ready = !v.slow || cyc[0];
            #1;
            if (done) begin
                seen = 1'b1;
            end else begin
                if (req_valid && req_ready) begin
                    chk(req_addr == AW'(exp_addr(v, k)), (k % v.x == 0) ? "R4" : "R3",
                        int'(req_addr), exp_addr(v, k));
                    chk(req_dir == v.dir && req_burst == v.burst, "R10",
                        {req_dir, req_burst}, {v.dir, v.burst});
                    last = exp_addr(v, k);
                    k++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        req_ready = 1'b0;
        chk(k == total, "R5", k, total);
        chk(seen && !busy, "R6", {seen, busy}, 2'b10);
        chk(req_addr == AW'((last + 1) & MASK), "R6", int'(req_addr), (last + 1) & MASK);
        @(negedge clk);
        chk(!done && req_addr == AW'((last + 1) & MASK), "R6", {done, req_addr}, (last + 1) & MASK);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !req_valid && !done && req_addr == '0, "R1",
            {busy, req_valid, done, req_addr}, 0);
        rst_n = 1'b1;

        // R8: start with zero line length (reset value) is rejected.
        wr(3'd0, 32'h0000_0123);
        chk(!busy && !req_valid, "R8", {busy, req_valid}, 0);
        @(negedge clk);
        chk(!busy && req_addr == '0, "R8", int'(req_addr), 0);

        // Table of walks.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: stop mid-walk.
        wr(3'd1, 32'd10);
        wr(3'd2, 32'd3);
        wr(3'd3, 32'd12);
        wr(3'd0, 32'h0500);
        req_ready = 1'b1;
        repeat (3) @(negedge clk);
        stop = 1'b1;
        #1;
        chk(!req_valid, "R7", req_valid, 0);
        @(negedge clk);
        stop = 1'b0; req_ready = 1'b0;
        #1;
        chk(!busy && !done && req_addr == 16'h0503, "R7", {busy, done, req_addr}, 16'h0503);
        @(negedge clk);
        chk(!done && !busy, "R7", {done, busy}, 0);

        // R9: writes during a walk are ignored.
        wr(3'd1, 32'd2);
        wr(3'd2, 32'd1);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h0700);
        wr(3'd1, 32'd9);
        wr(3'd4, 32'h30);
        wr(3'd0, 32'h5555);
        chk(busy && req_addr == 16'h0700 && !req_dir && !req_burst, "R9",
            {req_dir, req_burst, req_addr}, 16'h0700);
        // Next walk reuses the original values: 2 x 2 words, contiguous.
        run_vec('{16'h0700, 8'd2, 8'd1, 8'd2, 1'b0, 1'b0, 1'b0});

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule